// File: doc/BRIEF.md
# System-Control Coprocessor Register Write Decoder

This block takes the write side of a processor's system-control coprocessor. A move-to-coprocessor strobe arrives with a primary register number, a secondary register number, two opcode fields and a 32-bit data word. The block sends the word to the right control register for the memory protection unit or for the tightly coupled memories. The registers it can fill are these: two 8-bit cacheability masks (data side and instruction side), an 8-bit write-buffer mask, eight protection-region descriptors and two tightly-coupled-memory control words.

A write to the identification register number is illegal and raises an undefined-instruction pulse. For the register numbers that select a register through opcode2, an unknown opcode2 is dropped and raises an error pulse instead. The block also decodes every region descriptor and both memory control words into an enable, a byte base address and a byte size. It drives these as ready-made outputs for the address logic that uses them.

Top module: `sysctl_wr_decoder`

## Requirements
- R1: After a synchronous active-high reset, every stored register and both pulse outputs are zero. The decoded bases are then zero, the region sizes 2 and the memory sizes 512.
- R2: A write with crn=0 leaves every stored register unchanged. It raises `undef_pulse` for exactly the cycle after the write edge.
- R3: A write with crn=2 stores wdata[7:0] in `dcache_mask` when op2=0 and in `icache_mask` when op2=1.
- R4: A write with crn=3 and op2=0 stores wdata[7:0] in `wbuf_mask`.
- R5: A write with crn=2 or crn=3 and any opcode2 other than the ones listed in R3 and R4 changes no register. It raises `bad_op_pulse` for one cycle and leaves `undef_pulse` low.
- R6: A write with crn=6 stores the whole 32-bit word in region descriptor crm[2:0]. Bit 3 of crm is ignored, so crm=9 selects region 1.
- R7: For each region descriptor, `region_en` is bit 0 and `region_base` is the word with bits 11:0 cleared. `region_size` is 2 shifted left by bits 5:1, which gives 2 for a field of 0 and 2^32 for a field of 31.
- R8: A write with crn=9 stores the whole word in `dtcm_cfg` when op2=0 and in `itcm_cfg` when op2=1.
- R9: A write with crn=9 and op2 of 2..7 changes no register and raises `bad_op_pulse` for one cycle, with no `undef_pulse`.
- R10: For each memory control word, the base output is the word with bits 11:0 cleared. The size output is 512 shifted left by bits 5:1, which gives 2^40 for a field of 31.
- R11: A write with any crn other than 0, 2, 3, 6 or 9 (including 1, 5 and 7) changes no register and raises neither pulse. The op1 field never affects the result.
- R12: A cycle with `wr_en` low changes no register and leaves both pulses low in the next cycle. Back-to-back writes each take effect on their own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Coprocessor write strobe |
| crn | input | 4 | Primary register number |
| crm | input | 4 | Secondary register number |
| op1 | input | 3 | First opcode field (not decoded) |
| op2 | input | 3 | Second opcode field |
| wdata | input | 32 | Data word to write |
| dcache_mask | output | 8 | Data-side per-region cacheability bits |
| icache_mask | output | 8 | Instruction-side per-region cacheability bits |
| wbuf_mask | output | 8 | Data-side per-region write-buffer bits |
| region_cfg | output | 8x32 | Stored region descriptors, index 0..7 |
| region_en | output | 8 | Enable bit of each region |
| region_base | output | 8x32 | Decoded byte base of each region |
| region_size | output | 8x64 | Decoded byte size of each region |
| dtcm_cfg | output | 32 | Stored data memory control word |
| itcm_cfg | output | 32 | Stored instruction memory control word |
| dtcm_base | output | 32 | Decoded data memory base |
| itcm_base | output | 32 | Decoded instruction memory base |
| dtcm_size | output | 64 | Decoded data memory size |
| itcm_size | output | 64 | Decoded instruction memory size |
| undef_pulse | output | 1 | One-cycle undefined-instruction exception |
| bad_op_pulse | output | 1 | One-cycle illegal-opcode2 error flag |

## Verification
The checker watches every cycle for these properties. A trapped write leaves every stored register unchanged, and the two pulses never rise together. An idle strobe produces no pulse and changes nothing. Each decoded size is a single power of two, and each decoded base is aligned to 4 KiB. Only the bench's scenarios can show that each register number and opcode2 reaches the intended register and no other one. They also cover the folding of crm bits above the region index, the decoded values at the smallest and largest size fields, and the silent register numbers 1, 5 and 7 next to unlisted ones.

// File: rtl/sc_wr_pkg.sv
package sc_wr_pkg;

    parameter int DW       = 32;
    parameter int NREGION  = 8;
    parameter int RIDX_W   = $clog2(NREGION);
    parameter int MASK_W   = 8;
    parameter int SZ_W     = 64;
    parameter int FLD_LO   = 1;
    parameter int FLD_HI   = 5;
    parameter int BASE_LO  = 12;
    parameter int REGION_UNIT = 2;
    parameter int TCM_UNIT    = 512;

    localparam logic [3:0] CRN_ID     = 4'd0;
    localparam logic [3:0] CRN_CACHE  = 4'd2;
    localparam logic [3:0] CRN_WBUF   = 4'd3;
    localparam logic [3:0] CRN_REGION = 4'd6;
    localparam logic [3:0] CRN_TCM    = 4'd9;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_DCACHE,
        TGT_ICACHE,
        TGT_WBUF,
        TGT_REGION,
        TGT_DTCM,
        TGT_ITCM
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [RIDX_W-1:0] ridx;
        logic              undef;
        logic              bad;
    } route_t;

    function automatic logic [DW-1:0] base_of(input logic [DW-1:0] w);
        logic [DW-1:0] m;
        m = '1;
        m = m << BASE_LO;
        return w & m;
    endfunction

    function automatic logic [SZ_W-1:0] size_of(input logic [DW-1:0] w,
                                                 input int unsigned unit);
        logic [SZ_W-1:0] u;
        u = SZ_W'(unit);
        return u << w[FLD_HI:FLD_LO];
    endfunction

endpackage

// File: rtl/sc_route.sv
module sc_route
    import sc_wr_pkg::*;
(
    input  logic       wr_en,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op1,
    input  logic [2:0] op2,
    output route_t     rt
);
    logic unused_fields;
    assign unused_fields = ^{op1, crm};

    always_comb begin
        rt       = '0;
        rt.tgt   = TGT_NONE;
        rt.ridx  = crm[RIDX_W-1:0];
        if (wr_en) begin
            unique case (crn)
                CRN_ID: rt.undef = 1'b1;
                CRN_CACHE: begin
                    if (op2 == 3'd0)      rt.tgt = TGT_DCACHE;
                    else if (op2 == 3'd1) rt.tgt = TGT_ICACHE;
                    else                  rt.bad = 1'b1;
                end
                CRN_WBUF: begin
                    if (op2 == 3'd0) rt.tgt = TGT_WBUF;
                    else             rt.bad = 1'b1;
                end
                CRN_REGION: rt.tgt = TGT_REGION;
                CRN_TCM: begin
                    if (op2 == 3'd0)      rt.tgt = TGT_DTCM;
                    else if (op2 == 3'd1) rt.tgt = TGT_ITCM;
                    else                  rt.bad = 1'b1;
                end
                default: rt.tgt = TGT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sc_region_bank.sv
module sc_region_bank
    import sc_wr_pkg::*;
#(
    parameter int N  = NREGION,
    parameter int IW = $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [IW-1:0]           idx,
    input  logic [DW-1:0]           wdata,
    output logic [N-1:0][DW-1:0]    cfg,
    output logic [N-1:0]            en,
    output logic [N-1:0][DW-1:0]    base,
    output logic [N-1:0][SZ_W-1:0]  size
);
    for (genvar i = 0; i < N; i++) begin : g_region
        always_ff @(posedge clk) begin
            if (rst)
                cfg[i] <= '0;
            else if (we && idx == IW'(i))
                cfg[i] <= wdata;
        end
        assign en[i]   = cfg[i][0];
        assign base[i] = base_of(cfg[i]);
        assign size[i] = size_of(cfg[i], REGION_UNIT);
    end
endmodule

// File: rtl/sc_tcm_unit.sv
module sc_tcm_unit
    import sc_wr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    cfg,
    output logic [DW-1:0]    base,
    output logic [SZ_W-1:0]  size
);
    always_ff @(posedge clk) begin
        if (rst)     cfg <= '0;
        else if (we) cfg <= wdata;
    end
    assign base = base_of(cfg);
    assign size = size_of(cfg, TCM_UNIT);
endmodule

// File: rtl/sysctl_wr_decoder.sv
module sysctl_wr_decoder
    import sc_wr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [3:0]                    crn,
    input  logic [3:0]                    crm,
    input  logic [2:0]                    op1,
    input  logic [2:0]                    op2,
    input  logic [DW-1:0]                 wdata,
    output logic [MASK_W-1:0]             dcache_mask,
    output logic [MASK_W-1:0]             icache_mask,
    output logic [MASK_W-1:0]             wbuf_mask,
    output logic [NREGION-1:0][DW-1:0]    region_cfg,
    output logic [NREGION-1:0]            region_en,
    output logic [NREGION-1:0][DW-1:0]    region_base,
    output logic [NREGION-1:0][SZ_W-1:0]  region_size,
    output logic [DW-1:0]                 dtcm_cfg,
    output logic [DW-1:0]                 itcm_cfg,
    output logic [DW-1:0]                 dtcm_base,
    output logic [DW-1:0]                 itcm_base,
    output logic [SZ_W-1:0]               dtcm_size,
    output logic [SZ_W-1:0]               itcm_size,
    output logic                          undef_pulse,
    output logic                          bad_op_pulse
);
    route_t rt;

    sc_route u_route (
        .wr_en (wr_en),
        .crn   (crn),
        .crm   (crm),
        .op1   (op1),
        .op2   (op2),
        .rt    (rt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dcache_mask  <= '0;
            icache_mask  <= '0;
            wbuf_mask    <= '0;
            undef_pulse  <= 1'b0;
            bad_op_pulse <= 1'b0;
        end else begin
            undef_pulse  <= rt.undef;
            bad_op_pulse <= rt.bad;
            if (rt.tgt == TGT_DCACHE) dcache_mask <= wdata[MASK_W-1:0];
            if (rt.tgt == TGT_ICACHE) icache_mask <= wdata[MASK_W-1:0];
            if (rt.tgt == TGT_WBUF)   wbuf_mask   <= wdata[MASK_W-1:0];
        end
    end

    sc_region_bank #(.N(NREGION)) u_regions (
        .clk   (clk),
        .rst   (rst),
        .we    (rt.tgt == TGT_REGION),
        .idx   (rt.ridx),
        .wdata (wdata),
        .cfg   (region_cfg),
        .en    (region_en),
        .base  (region_base),
        .size  (region_size)
    );

    sc_tcm_unit u_dtcm (
        .clk   (clk),
        .rst   (rst),
        .we    (rt.tgt == TGT_DTCM),
        .wdata (wdata),
        .cfg   (dtcm_cfg),
        .base  (dtcm_base),
        .size  (dtcm_size)
    );

    sc_tcm_unit u_itcm (
        .clk   (clk),
        .rst   (rst),
        .we    (rt.tgt == TGT_ITCM),
        .wdata (wdata),
        .cfg   (itcm_cfg),
        .base  (itcm_base),
        .size  (itcm_size)
    );
endmodule

// File: rtl/sysctl_wr_decoder_chk.sv
module sysctl_wr_decoder_chk
    import sc_wr_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          wr_en,
    input logic [MASK_W-1:0]             dcache_mask,
    input logic [MASK_W-1:0]             icache_mask,
    input logic [MASK_W-1:0]             wbuf_mask,
    input logic [NREGION-1:0][DW-1:0]    region_cfg,
    input logic [NREGION-1:0][DW-1:0]    region_base,
    input logic [NREGION-1:0][SZ_W-1:0]  region_size,
    input logic [DW-1:0]                 dtcm_cfg,
    input logic [DW-1:0]                 itcm_cfg,
    input logic [DW-1:0]                 dtcm_base,
    input logic [SZ_W-1:0]               dtcm_size,
    input logic [SZ_W-1:0]               itcm_size,
    input logic                          undef_pulse,
    input logic                          bad_op_pulse
);
    logic [MASK_W*3+DW*(NREGION+2)-1:0] state_vec;
    assign state_vec = {dcache_mask, icache_mask, wbuf_mask, region_cfg, dtcm_cfg, itcm_cfg};

    // R2
    trap_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
        (undef_pulse && !$past(rst)) |-> $stable(state_vec));

    // R5
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(undef_pulse && bad_op_pulse));

    // R12
    idle_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> (!undef_pulse && !bad_op_pulse));

    // R12
    idle_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |-> $stable(state_vec));

    // R10
    tcm_size_pow2_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(dtcm_size) == 1) && ($countones(itcm_size) == 1));

    // R10
    tcm_base_align_chk: assert property (@(posedge clk) disable iff (rst)
        dtcm_base[BASE_LO-1:0] == '0);

    for (genvar i = 0; i < NREGION; i++) begin : g_rchk
        // R7
        region_size_pow2_chk: assert property (@(posedge clk) disable iff (rst)
            $countones(region_size[i]) == 1);
        // R7
        region_base_align_chk: assert property (@(posedge clk) disable iff (rst)
            region_base[i][BASE_LO-1:0] == '0);
    end
endmodule

bind sysctl_wr_decoder sysctl_wr_decoder_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .dcache_mask  (dcache_mask),
    .icache_mask  (icache_mask),
    .wbuf_mask    (wbuf_mask),
    .region_cfg   (region_cfg),
    .region_base  (region_base),
    .region_size  (region_size),
    .dtcm_cfg     (dtcm_cfg),
    .itcm_cfg     (itcm_cfg),
    .dtcm_base    (dtcm_base),
    .dtcm_size    (dtcm_size),
    .itcm_size    (itcm_size),
    .undef_pulse  (undef_pulse),
    .bad_op_pulse (bad_op_pulse)
);

// File: tb/test_sysctl_wr_decoder.sv
`timescale 1ns/1ps
module test_sysctl_wr_decoder;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               wr_en = 1'b0;
    logic [3:0]         crn = '0;
    logic [3:0]         crm = '0;
    logic [2:0]         op1 = '0;
    logic [2:0]         op2 = '0;
    logic [31:0]        wdata = '0;
    logic [7:0]         dcache_mask, icache_mask, wbuf_mask;
    logic [7:0][31:0]   region_cfg, region_base;
    logic [7:0]         region_en;
    logic [7:0][63:0]   region_size;
    logic [31:0]        dtcm_cfg, itcm_cfg, dtcm_base, itcm_base;
    logic [63:0]        dtcm_size, itcm_size;
    logic               undef_pulse, bad_op_pulse;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";
    bit finished = 0;

    always #2.5 clk = ~clk;

    sysctl_wr_decoder i_sysctl_wr_decoder (
        .clk(clk), .rst(rst), .wr_en(wr_en), .crn(crn), .crm(crm), .op1(op1), .op2(op2),
        .wdata(wdata), .dcache_mask(dcache_mask), .icache_mask(icache_mask),
        .wbuf_mask(wbuf_mask), .region_cfg(region_cfg), .region_en(region_en),
        .region_base(region_base), .region_size(region_size), .dtcm_cfg(dtcm_cfg),
        .itcm_cfg(itcm_cfg), .dtcm_base(dtcm_base), .itcm_base(itcm_base),
        .dtcm_size(dtcm_size), .itcm_size(itcm_size), .undef_pulse(undef_pulse),
        .bad_op_pulse(bad_op_pulse)
    );

    // behavioural reference state
    logic [7:0]  m_dc, m_ic, m_wb;
    logic [31:0] m_rg [8];
    logic [31:0] m_dt, m_it;
    bit          m_un, m_bd;

    always @(posedge clk) begin
        if (rst) begin
            m_dc = 0; m_ic = 0; m_wb = 0; m_dt = 0; m_it = 0; m_un = 0; m_bd = 0;
            for (int k = 0; k < 8; k++) m_rg[k] = 0;
        end else begin
            m_un = 0; m_bd = 0;
            if (wr_en) begin
                case (int'(crn))
                    0: m_un = 1;
                    2: if (op2 == 0) m_dc = wdata[7:0];
                       else if (op2 == 1) m_ic = wdata[7:0];
                       else m_bd = 1;
                    3: if (op2 == 0) m_wb = wdata[7:0]; else m_bd = 1;
                    6: m_rg[int'(crm) % 8] = wdata;
                    9: if (op2 == 0) m_dt = wdata;
                       else if (op2 == 1) m_it = wdata;
                       else m_bd = 1;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] xsize(input logic [31:0] w, input int unit);
        logic [63:0] s;
        s = 64'(unit);
        for (int k = 0; k < int'(w[5:1]); k++) s = s * 2;
        return s;
    endfunction

    task automatic compare_all();
        chk(dcache_mask == m_dc, "dcache_mask", 64'(dcache_mask), 64'(m_dc));
        chk(icache_mask == m_ic, "icache_mask", 64'(icache_mask), 64'(m_ic));
        chk(wbuf_mask == m_wb, "wbuf_mask", 64'(wbuf_mask), 64'(m_wb));
        chk(undef_pulse == m_un, "undef_pulse", 64'(undef_pulse), 64'(m_un));
        chk(bad_op_pulse == m_bd, "bad_op_pulse", 64'(bad_op_pulse), 64'(m_bd));
        chk(dtcm_cfg == m_dt, "dtcm_cfg", 64'(dtcm_cfg), 64'(m_dt));
        chk(itcm_cfg == m_it, "itcm_cfg", 64'(itcm_cfg), 64'(m_it));
        chk(dtcm_base == {m_dt[31:12], 12'h0}, "dtcm_base", 64'(dtcm_base), 64'({m_dt[31:12], 12'h0}));
        chk(itcm_base == {m_it[31:12], 12'h0}, "itcm_base", 64'(itcm_base), 64'({m_it[31:12], 12'h0}));
        chk(dtcm_size == xsize(m_dt, 512), "dtcm_size", dtcm_size, xsize(m_dt, 512));
        chk(itcm_size == xsize(m_it, 512), "itcm_size", itcm_size, xsize(m_it, 512));
        for (int k = 0; k < 8; k++) begin
            chk(region_cfg[k] == m_rg[k], $sformatf("region_cfg[%0d]", k), 64'(region_cfg[k]), 64'(m_rg[k]));
            chk(region_en[k] == m_rg[k][0], $sformatf("region_en[%0d]", k), 64'(region_en[k]), 64'(m_rg[k][0]));
            chk(region_base[k] == {m_rg[k][31:12], 12'h0}, $sformatf("region_base[%0d]", k),
                64'(region_base[k]), 64'({m_rg[k][31:12], 12'h0}));
            chk(region_size[k] == xsize(m_rg[k], 2), $sformatf("region_size[%0d]", k),
                region_size[k], xsize(m_rg[k], 2));
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!finished) compare_all();
    end

    task automatic wr(input string req, input int n, input int m, input int o1, input int o2, input logic [31:0] d);
        @(negedge clk);
        cur_req = req;
        wr_en = 1; crn = 4'(n); crm = 4'(m); op1 = 3'(o1); op2 = 3'(o2); wdata = d;
    endtask

    task automatic idle(input string req, input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            cur_req = req;
            wr_en = 0;
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst = 0;
        idle("R1", 2);
        // R3: cache masks, upper data bits discarded
        wr("R3", 2, 0, 0, 0, 32'hFFFF_FF5A);
        wr("R3", 2, 3, 7, 1, 32'h1234_56C3);
        // R4
        wr("R4", 3, 0, 0, 0, 32'hDEAD_BE81);
        // R5: illegal op2 on crn 2 and 3
        wr("R5", 2, 0, 0, 2, 32'h0000_0000);
        wr("R5", 3, 0, 0, 1, 32'h0000_0000);
        wr("R5", 2, 0, 0, 7, 32'hFFFF_FFFF);
        // R6 / R7: all regions, with boundary size fields
        for (int k = 0; k < 8; k++)
            wr("R6", 2'(0) + 6, k, 0, k % 8, {20'(32'h10 * (k + 1)), 6'h0, 5'(k * 4 + 3), 1'(k % 2)});
        wr("R7", 6, 2, 0, 0, 32'hFFFF_F03F);
        wr("R7", 6, 3, 0, 0, 32'h0800_0000);
        wr("R6", 6, 9, 0, 0, 32'hABCD_E00B);
        wr("R6", 6, 15, 0, 0, 32'h0000_1041);
        // R8 / R10
        wr("R8", 9, 1, 0, 0, 32'h0080_000A);
        wr("R8", 9, 1, 0, 1, 32'h0000_0020);
        wr("R10", 9, 0, 0, 0, 32'hFFFF_FFFF);
        wr("R10", 9, 0, 0, 1, 32'h0000_0000);
        // R9
        wr("R9", 9, 0, 0, 2, 32'h5555_5555);
        wr("R9", 9, 0, 0, 5, 32'h1111_1111);
        // R2: trap on crn 0
        wr("R2", 0, 0, 0, 0, 32'hFFFF_FFFF);
        wr("R2", 0, 6, 3, 1, 32'h1234_5678);
        idle("R2", 1);
        // R11: silent and unlisted register numbers, op1 ignored
        wr("R11", 1, 0, 0, 0, 32'hFFFF_FFFF);
        wr("R11", 5, 0, 0, 2, 32'hFFFF_FFFF);
        wr("R11", 7, 5, 0, 1, 32'hFFFF_FFFF);
        wr("R11", 4, 0, 0, 0, 32'hFFFF_FFFF);
        wr("R11", 15, 0, 0, 0, 32'hFFFF_FFFF);
        wr("R11", 2, 0, 5, 0, 32'h0000_0042);
        // R12: strobe low with live fields, then back-to-back
        @(negedge clk);
        cur_req = "R12";
        wr_en = 0; crn = 4'd2; op2 = 3'd0; wdata = 32'h0000_00FF;
        @(negedge clk);
        crn = 4'd0;
        wr("R12", 3, 0, 0, 0, 32'h0000_0011);
        wr("R12", 3, 0, 0, 0, 32'h0000_0022);
        wr("R12", 0, 0, 0, 0, 32'h0);
        wr("R12", 2, 0, 0, 4, 32'h0);
        idle("R12", 3);
        // R1: reset again clears everything
        @(negedge clk);
        cur_req = "R1";
        rst = 1;
        idle("R1", 2);
        @(negedge clk);
        rst = 0;
        idle("R1", 2);
        finish_run();
    end
endmodule